// File: doc/BRIEF.md
# Bus error response substitution

This block sits between the processor-side response logic and the two paths that can answer a processor access: local memory and the PCI initiator. When an access reaches an address where no memory is fitted, or a PCI cycle that no target claims, the block does not raise the transfer error acknowledge. Instead it completes the access quietly, and every data beat reads as all ones. Accesses that end normally pass straight through. The data, the acknowledge and any unrelated error acknowledge are not changed.

The block also detects the unclaimed PCI cycle itself. After each PCI address phase it counts cycles while it waits for a target to claim the cycle. If the count runs out, it raises a one-cycle abort pulse. It then gives the processor one acknowledged all-ones beat for each beat the access expected. On the PCI target side, a memory read from a PCI master that hits unpopulated memory returns all ones on the 32-bit data path. A sticky flag records that a substitution happened. A configuration read of the flag clears it.

Top module: `quiet_fault_fill`

## Requirements
- R1: A memory beat (`mem_ack`=1) with `mem_sel_err`=1 gives `cpu_ack`=1 and `cpu_rdata`=64'hFFFF_FFFF_FFFF_FFFF in the same cycle.
- R2: A memory beat with `mem_sel_err`=0 gives `cpu_ack`=1, `cpu_rdata`=`mem_rdata` and `cpu_tea`=`path_tea` in the same cycle.
- R3: When no fill or memory beat is active, a PCI beat (`pci_ack`=1) gives `cpu_ack`=1 and `cpu_rdata`=`pci_rdata` unchanged, in the same cycle.
- R4: Suppose `pci_addr_phase` is high in cycle A and is not high again in cycles A+1 to A+4. If `pci_devsel` stays low in each of those four cycles, `pci_mabort` is high for exactly one cycle, cycle A+5.
- R5: If `pci_devsel` is high in any one of cycles A+1 to A+4, no `pci_mabort` follows for that address phase.
- R6: A new `pci_addr_phase` restarts the wait window. Only the newest address phase can time out, and its pulse comes five cycles after it.
- R7: After an abort, `cpu_ack`=1 with all-ones `cpu_rdata` for N consecutive cycles, starting in the cycle of the `pci_mabort` pulse. N is the value of `pci_beats` sampled with the address phase. A value of 0 counts as 1. These fill beats take priority over the memory and PCI paths.
- R8: `cpu_tea` is 0 during every fill beat and during every memory beat that has `mem_sel_err`=1, even when `path_tea`=1.
- R9: On the target side, `tgt_rdata` is 32'hFFFF_FFFF when `tgt_phase` and `tgt_sel_err` are both 1. Otherwise it equals `tgt_mem_rdata`.
- R10: `subst_flag` goes to 1 in the cycle after an R1 or R9 substitution, and in the cycle of the abort pulse. It goes to 0 in the cycle after `cfg_stat_rd`. If a setting event and the clear happen in the same cycle, the flag is set.
- R11: After synchronous reset, `subst_flag`, `pci_mabort` and `cpu_ack` are 0 while all inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ack | input | 1 | Memory path presents a beat |
| mem_sel_err | input | 1 | That beat hit no fitted memory |
| mem_rdata | input | 64 | Memory beat data |
| pci_ack | input | 1 | PCI initiator presents a beat for the processor |
| pci_rdata | input | 64 | PCI beat data |
| path_tea | input | 1 | Error acknowledge requested by the paths for other faults |
| pci_addr_phase | input | 1 | PCI address phase of a processor-initiated cycle |
| pci_beats | input | 3 | Beats expected by that cycle, sampled with the address phase |
| pci_devsel | input | 1 | A target has claimed the cycle |
| tgt_phase | input | 1 | Data phase of a PCI-initiated memory read |
| tgt_sel_err | input | 1 | That read hit no fitted memory |
| tgt_mem_rdata | input | 32 | Memory data for the PCI target path |
| cfg_stat_rd | input | 1 | Configuration read of the status flag (clears it) |
| cpu_ack | output | 1 | Transfer acknowledge to the processor |
| cpu_rdata | output | 64 | Read data to the processor |
| cpu_tea | output | 1 | Transfer error acknowledge to the processor |
| pci_mabort | output | 1 | One-cycle master abort pulse |
| tgt_rdata | output | 32 | Read data to the PCI master |
| subst_flag | output | 1 | Sticky substitution-seen flag |

## Verification
The bench checks the edges of the claim window. A claim in the fourth cycle must still prevent the abort. A design that counts from the address phase itself, or that stops one cycle short, would abort that cycle or pulse a cycle early. A second address phase in mid-window must push the pulse out, or a stale timeout would fire. A beat count of zero, and the error acknowledge held high during a fill, check that the fill neither drops its only beat nor lets the error through. The flag test makes a set and a clear meet in the same cycle, and a design with the wrong priority would lose the event.

// File: rtl/qf_pkg.sv
package qf_pkg;

    localparam int unsigned CPU_DW_DEF  = 64;
    localparam int unsigned PCI_DW_DEF  = 32;
    localparam int unsigned BEAT_W_DEF  = 3;
    localparam int unsigned WINDOW_DEF  = 4;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FILL = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_PCI  = 2'd3
    } resp_src_e;

    // Beat count normaliser: a zero count still yields one beat.
    function automatic logic [BEAT_W_DEF-1:0] norm_beats(input logic [BEAT_W_DEF-1:0] b);
        return (b == '0) ? BEAT_W_DEF'(1) : b;
    endfunction

endpackage

// File: rtl/qf_devsel_timer.sv
module qf_devsel_timer #(
    parameter int unsigned WINDOW = qf_pkg::WINDOW_DEF,
    localparam int unsigned CNT_W = (WINDOW < 2) ? 1 : $clog2(WINDOW)
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_phase,
    input  logic devsel,
    output logic timeout,
    output logic abort_q
);
    logic             armed;
    logic [CNT_W-1:0] wait_cnt;

    assign timeout = armed && !addr_phase && !devsel &&
                     (wait_cnt == CNT_W'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            wait_cnt <= '0;
            abort_q  <= 1'b0;
        end else begin
            abort_q <= timeout;
            if (addr_phase) begin
                armed    <= 1'b1;
                wait_cnt <= '0;
            end else if (armed) begin
                if (devsel || timeout) begin
                    armed <= 1'b0;
                end else begin
                    wait_cnt <= wait_cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/qf_beat_filler.sv
module qf_beat_filler #(
    parameter int unsigned BEAT_W = qf_pkg::BEAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_phase,
    input  logic [BEAT_W-1:0] beats,
    input  logic              start,
    output logic              active
);
    logic [BEAT_W-1:0] beats_q;
    logic [BEAT_W-1:0] left;

    assign active = (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= '0;
            left    <= '0;
        end else begin
            if (addr_phase) begin
                beats_q <= beats;
            end
            if (start) begin
                left <= qf_pkg::norm_beats(beats_q);
            end else if (active) begin
                left <= left - BEAT_W'(1);
            end
        end
    end
endmodule

// File: rtl/qf_cpu_resp.sv
module qf_cpu_resp #(
    parameter int unsigned DW = qf_pkg::CPU_DW_DEF
) (
    input  logic          fill,
    input  logic          mem_ack,
    input  logic          mem_sel_err,
    input  logic [DW-1:0] mem_rdata,
    input  logic          pci_ack,
    input  logic [DW-1:0] pci_rdata,
    input  logic          path_tea,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          tea,
    output logic          mem_subst
);
    import qf_pkg::*;
    resp_src_e src;

    always_comb begin
        if (fill)         src = SRC_FILL;
        else if (mem_ack) src = SRC_MEM;
        else if (pci_ack) src = SRC_PCI;
        else              src = SRC_NONE;
    end

    assign mem_subst = (src == SRC_MEM) && mem_sel_err;

    always_comb begin
        ack   = (src != SRC_NONE);
        rdata = '0;
        tea   = path_tea;
        unique case (src)
            SRC_FILL: begin
                rdata = '1;
                tea   = 1'b0;
            end
            SRC_MEM: begin
                rdata = mem_sel_err ? '1 : mem_rdata;
                if (mem_sel_err) tea = 1'b0;
            end
            SRC_PCI:  rdata = pci_rdata;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/qf_tgt_resp.sv
module qf_tgt_resp #(
    parameter int unsigned DW = qf_pkg::PCI_DW_DEF
) (
    input  logic          phase,
    input  logic          sel_err,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rdata,
    output logic          subst
);
    assign subst = phase && sel_err;
    assign rdata = subst ? '1 : mem_rdata;
endmodule

// File: rtl/quiet_fault_fill.sv
module quiet_fault_fill #(
    parameter int unsigned CPU_DW = qf_pkg::CPU_DW_DEF,
    parameter int unsigned PCI_DW = qf_pkg::PCI_DW_DEF,
    parameter int unsigned BEAT_W = qf_pkg::BEAT_W_DEF,
    parameter int unsigned WINDOW = qf_pkg::WINDOW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_ack,
    input  logic              mem_sel_err,
    input  logic [CPU_DW-1:0] mem_rdata,
    input  logic              pci_ack,
    input  logic [CPU_DW-1:0] pci_rdata,
    input  logic              path_tea,
    input  logic              pci_addr_phase,
    input  logic [BEAT_W-1:0] pci_beats,
    input  logic              pci_devsel,
    input  logic              tgt_phase,
    input  logic              tgt_sel_err,
    input  logic [PCI_DW-1:0] tgt_mem_rdata,
    input  logic              cfg_stat_rd,
    output logic              cpu_ack,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              cpu_tea,
    output logic              pci_mabort,
    output logic [PCI_DW-1:0] tgt_rdata,
    output logic              subst_flag
);
    logic timeout;
    logic fill_active;
    logic mem_subst;
    logic tgt_subst;

    qf_devsel_timer #(.WINDOW(WINDOW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .addr_phase (pci_addr_phase),
        .devsel     (pci_devsel),
        .timeout    (timeout),
        .abort_q    (pci_mabort)
    );

    qf_beat_filler #(.BEAT_W(BEAT_W)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .addr_phase (pci_addr_phase),
        .beats      (pci_beats),
        .start      (timeout),
        .active     (fill_active)
    );

    qf_cpu_resp #(.DW(CPU_DW)) u_cpu (
        .fill        (fill_active),
        .mem_ack     (mem_ack),
        .mem_sel_err (mem_sel_err),
        .mem_rdata   (mem_rdata),
        .pci_ack     (pci_ack),
        .pci_rdata   (pci_rdata),
        .path_tea    (path_tea),
        .ack         (cpu_ack),
        .rdata       (cpu_rdata),
        .tea         (cpu_tea),
        .mem_subst   (mem_subst)
    );

    qf_tgt_resp #(.DW(PCI_DW)) u_tgt (
        .phase     (tgt_phase),
        .sel_err   (tgt_sel_err),
        .mem_rdata (tgt_mem_rdata),
        .rdata     (tgt_rdata),
        .subst     (tgt_subst)
    );

    // Sticky flag: any setting event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            subst_flag <= 1'b0;
        end else if (timeout || mem_subst || tgt_subst) begin
            subst_flag <= 1'b1;
        end else if (cfg_stat_rd) begin
            subst_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/quiet_fault_fill_chk.sv
module quiet_fault_fill_chk #(
    parameter int unsigned CPU_DW = 64,
    parameter int unsigned PCI_DW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_ack,
    input logic              mem_sel_err,
    input logic              pci_devsel,
    input logic              tgt_phase,
    input logic              tgt_sel_err,
    input logic              cpu_ack,
    input logic [CPU_DW-1:0] cpu_rdata,
    input logic              cpu_tea,
    input logic              pci_mabort,
    input logic [PCI_DW-1:0] tgt_rdata,
    input logic              subst_flag
);
    // R1 and R8: a select error completes quietly with all ones
    a_r1_mem_err_ones: assert property (@(posedge clk) disable iff (rst)
        (mem_ack && mem_sel_err) |-> (cpu_ack && cpu_rdata == '1 && !cpu_tea));

    // R4: the abort is a single-cycle pulse
    a_r4_abort_pulse: assert property (@(posedge clk) disable iff (rst)
        pci_mabort |=> !pci_mabort);

    // R5: a claim in this cycle rules out an abort in the next
    a_r5_claim_blocks: assert property (@(posedge clk) disable iff (rst)
        pci_devsel |=> !pci_mabort);

    // R7 and R8: the first fill beat arrives with the pulse and is quiet
    a_r7_fill_on_abort: assert property (@(posedge clk) disable iff (rst)
        pci_mabort |-> (cpu_ack && cpu_rdata == '1 && !cpu_tea));

    // R9: target side substitution
    a_r9_tgt_ones: assert property (@(posedge clk) disable iff (rst)
        (tgt_phase && tgt_sel_err) |-> (tgt_rdata == '1));

    // R10: the flag is up whenever the abort pulse is
    a_r10_flag_on_abort: assert property (@(posedge clk) disable iff (rst)
        pci_mabort |-> subst_flag);

    // R10: the flag rises after a target substitution
    a_r10_flag_on_tgt: assert property (@(posedge clk) disable iff (rst)
        (tgt_phase && tgt_sel_err) |=> subst_flag);
endmodule

bind quiet_fault_fill quiet_fault_fill_chk #(.CPU_DW(CPU_DW), .PCI_DW(PCI_DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_ack     (mem_ack),
    .mem_sel_err (mem_sel_err),
    .pci_devsel  (pci_devsel),
    .tgt_phase   (tgt_phase),
    .tgt_sel_err (tgt_sel_err),
    .cpu_ack     (cpu_ack),
    .cpu_rdata   (cpu_rdata),
    .cpu_tea     (cpu_tea),
    .pci_mabort  (pci_mabort),
    .tgt_rdata   (tgt_rdata),
    .subst_flag  (subst_flag)
);

// File: tb/quiet_fault_fill_tb_top.sv
module quiet_fault_fill_tb_top;
    localparam logic [63:0] ONES64 = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_ack = 0, mem_sel_err = 0, pci_ack = 0, path_tea = 0;
    logic [63:0] mem_rdata = '0, pci_rdata = '0;
    logic        pci_addr_phase = 0, pci_devsel = 0;
    logic [2:0]  pci_beats = '0;
    logic        tgt_phase = 0, tgt_sel_err = 0, cfg_stat_rd = 0;
    logic [31:0] tgt_mem_rdata = '0;
    wire         cpu_ack, cpu_tea, pci_mabort, subst_flag;
    wire  [63:0] cpu_rdata;
    wire  [31:0] tgt_rdata;

    always #10 clk = ~clk;

    quiet_fault_fill dut_i (
        .clk(clk), .rst(rst),
        .mem_ack(mem_ack), .mem_sel_err(mem_sel_err), .mem_rdata(mem_rdata),
        .pci_ack(pci_ack), .pci_rdata(pci_rdata), .path_tea(path_tea),
        .pci_addr_phase(pci_addr_phase), .pci_beats(pci_beats), .pci_devsel(pci_devsel),
        .tgt_phase(tgt_phase), .tgt_sel_err(tgt_sel_err), .tgt_mem_rdata(tgt_mem_rdata),
        .cfg_stat_rd(cfg_stat_rd),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_tea(cpu_tea),
        .pci_mabort(pci_mabort), .tgt_rdata(tgt_rdata), .subst_flag(subst_flag)
    );

    typedef struct {
        logic [63:0] data;
        logic        tea;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0;
    int   mon_checks = 0, mon_errors = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per acknowledged beat
    always @(negedge clk) begin
        if (!rst && cpu_ack) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_errors++;
                $display("FAIL unexpected beat: actual=%h expected=none", cpu_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (cpu_rdata !== e.data || cpu_tea !== e.tea) begin
                    mon_errors++;
                    $display("FAIL %s beat: actual=%h/tea%0b expected=%h/tea%0b",
                             e.req, cpu_rdata, cpu_tea, e.data, e.tea);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
        mem_ack = 0; mem_sel_err = 0; pci_ack = 0; path_tea = 0;
        pci_addr_phase = 0; pci_devsel = 0; tgt_phase = 0; tgt_sel_err = 0;
        cfg_stat_rd = 0;
    endtask

    task automatic mem_beat(input logic [63:0] d, input bit err, input bit tea,
                            input string req);
        exp_t e;
        @(posedge clk); #1;
        mem_ack = 1; mem_sel_err = err; mem_rdata = d; path_tea = tea;
        e.data = err ? ONES64 : d;
        e.tea  = err ? 1'b0 : tea;
        e.req  = req;
        exp_q.push_back(e);
        idle(1);
    endtask

    task automatic pci_beat(input logic [63:0] d);
        exp_t e;
        @(posedge clk); #1;
        pci_ack = 1; pci_rdata = d;
        e.data = d; e.tea = 0; e.req = "R3";
        exp_q.push_back(e);
        idle(1);
    endtask

    // Address phase in cycle A; optional claim at A+claim_at; optional
    // restart at A+restart_at; tea_hold keeps path_tea high throughout.
    task automatic pci_cycle(input int beats, input int claim_at,
                             input int restart_at, input bit tea_hold,
                             input string req);
        int abort_k;
        int n;
        abort_k = (claim_at != 0) ? -1 : ((restart_at != 0) ? restart_at + 5 : 5);
        n = (beats == 0) ? 1 : beats;
        if (abort_k > 0) begin
            for (int i = 0; i < n; i++) begin
                exp_t e;
                e.data = ONES64; e.tea = 0; e.req = "R7";
                exp_q.push_back(e);
            end
        end
        @(posedge clk); #1;
        pci_addr_phase = 1; pci_beats = 3'(beats); path_tea = tea_hold;
        for (int k = 1; k <= restart_at + 6; k++) begin
            @(posedge clk); #1;
            pci_addr_phase = (k == restart_at);
            pci_devsel = (k == claim_at);
            path_tea = tea_hold;
            @(negedge clk);
            check(pci_mabort === (k == abort_k), req, $sformatf("abort at +%0d", k),
                  64'(pci_mabort), 64'(k == abort_k));
        end
        repeat (n + 2) @(negedge clk);
        idle(1);
    endtask

    task automatic tgt_read(input logic [31:0] d, input bit err);
        @(posedge clk); #1;
        tgt_phase = 1; tgt_sel_err = err; tgt_mem_rdata = d;
        @(negedge clk);
        check(tgt_rdata === (err ? 32'hFFFF_FFFF : d), "R9", "target data",
              64'(tgt_rdata), 64'(err ? 32'hFFFF_FFFF : d));
        idle(1);
    endtask

    task automatic flag_is(input bit v, input string what);
        @(negedge clk);
        check(subst_flag === v, "R10", what, 64'(subst_flag), 64'(v));
    endtask

    task automatic clear_flag();
        @(posedge clk); #1;
        cfg_stat_rd = 1;
        idle(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks",
                     errors + mon_errors, checks + mon_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R11: idle outputs after reset
        check(subst_flag === 0, "R11", "flag", 64'(subst_flag), 0);
        check(pci_mabort === 0, "R11", "abort", 64'(pci_mabort), 0);
        check(cpu_ack === 0, "R11", "ack", 64'(cpu_ack), 0);

        // R2: normal memory beats pass, including the error acknowledge
        mem_beat(64'h0123_4567_89AB_CDEF, 0, 0, "R2");
        mem_beat(64'hDEAD_BEEF_0000_1111, 0, 1, "R2");
        flag_is(0, "no set on clean beat");
        // R3: PCI data pass-through
        pci_beat(64'h5555_AAAA_1234_0000);
        // R1/R8: select error, error acknowledge requested but suppressed
        mem_beat(64'h0000_0000_0000_0042, 1, 1, "R1");
        flag_is(1, "set by memory substitution");
        clear_flag();
        flag_is(0, "cleared by config read");

        // R4/R7: single-beat abort and 4-beat burst abort
        pci_cycle(1, 0, 0, 0, "R4");
        flag_is(1, "set by abort");
        clear_flag();
        pci_cycle(4, 0, 0, 0, "R7");
        // R7: zero beat count yields one beat; R8 with tea held high
        pci_cycle(0, 0, 0, 1, "R8");
        // R5: claims at the first and last cycle of the window
        pci_cycle(2, 1, 0, 0, "R5");
        pci_cycle(2, 4, 0, 0, "R5");
        // R6: restart mid-window
        pci_cycle(2, 0, 3, 0, "R6");

        // R9: target side
        clear_flag();
        flag_is(0, "cleared before target test");
        tgt_read(32'hCAFE_F00D, 0);
        flag_is(0, "no set on clean target read");
        tgt_read(32'h1357_9BDF, 1);
        flag_is(1, "set by target substitution");

        // R10: set wins over a clear in the same cycle
        clear_flag();
        @(posedge clk); #1;
        mem_ack = 1; mem_sel_err = 1; mem_rdata = '0; cfg_stat_rd = 1;
        begin
            exp_t e;
            e.data = ONES64; e.tea = 0; e.req = "R1";
            exp_q.push_back(e);
        end
        idle(1);
        flag_is(1, "set wins over clear");

        idle(3);
        check(exp_q.size() == 0, "R7", "missing beats", 64'(exp_q.size()), 0);
        finish_run();
    end
endmodule